// File: doc/BRIEF.md
# Ping-Pong DMA Channel Sequencer

This block sequences one DMA channel through a chain of tasks. Two descriptors, called primary and alternate, take turns. Each descriptor holds a 3-bit control code, a transfer count and a burst exponent. When one task ends, the channel moves to the other descriptor. The host can refill the descriptor that just finished while the next task runs, so a long chain of tasks needs no stall for reprogramming.

Inside a task, the channel moves data one word at a time on a request/acknowledge memory port. After every 2^exponent words it gives up the port and waits to be picked again. It is picked again when its request line is seen while the grant input is high. The grant input stands in for the multi-channel arbiter, which lies outside this block. Every finished task raises a one-cycle done pulse, and the finished descriptor's control code is written back as "stopped". The chain ends when the channel loads a descriptor that is not marked ping-pong, or when the host clears the enable.

Top module: `pp_dma_seq`

## Requirements
- R1: After reset, and again whenever the channel is enabled, `active_alt` is 0 (primary first). After reset, `mem_req`, `done` and `wr_err` are 0. Enabling the channel clears `wr_err`.
- R2: A descriptor is runnable only when its control code is 3'b011. If the channel loads a descriptor with any other code (3'b000 means stop), it makes no further transfers until it is disabled and enabled again.
- R3: The count field holds the number of transfers minus one, so a field value of 0 gives exactly one transfer.
- R4: A burst starts only in a cycle where `chan_req` and `grant` are both high. After 2^exponent acknowledged transfers, `mem_req` drops. It stays low until the next such start.
- R5: When fewer than 2^exponent transfers remain, the last burst of a task makes only those transfers. For example, a six-word task with exponent 2 runs bursts of 4 and 2.
- R6: `done` is high for exactly one cycle. That cycle is the one after the task's last acknowledged transfer. In the same cycle, `active_alt` has flipped to the other descriptor.
- R7: When a task completes, the finished descriptor's control code becomes 3'b000. The host reads this code on `rd_cc` for the descriptor chosen by `host_sel` (0 primary, 1 alternate).
- R8: A host write to the descriptor that is not running takes effect. This allows a chain of five tasks to run back to back, each with its own count and exponent.
- R9: While a task is loaded, arbitrating or transferring, a host write to the running descriptor is dropped. The write sets `wr_err`, which stays set until the next enable.
- R10: When `chan_en` is low, `mem_req` is low from the next cycle on. The task in progress is abandoned. A later enable restarts from the primary descriptor with its full count.
- R11: While `grant` is low, no burst starts, even if `chan_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| chan_req | input | 1 | Transfer request for this channel |
| grant | input | 1 | Channel holds highest priority |
| mem_req | output | 1 | Single-word transfer request |
| mem_ack | input | 1 | Transfer accepted this cycle |
| done | output | 1 | One-cycle task completion pulse |
| active_alt | output | 1 | 0 primary running, 1 alternate running |
| host_we | input | 1 | Descriptor write strobe |
| host_sel | input | 1 | Descriptor chosen for write and read |
| host_cc | input | 3 | Control code to write |
| host_cnt | input | CNT_W | Transfer count minus one to write |
| host_exp | input | EXP_W | Burst exponent to write |
| rd_cc | output | 3 | Control code of the chosen descriptor |
| wr_err | output | 1 | Sticky: write to running descriptor refused |

## Verification
The hardest case to reach is the handover between tasks while the host refills a descriptor. A completion must flip the active descriptor, and a host write to the just-finished descriptor must be accepted, not refused. The stimulus runs a five-task chain with mixed counts and exponents. It rewrites each finished descriptor right after its done pulse and lets the last write-back end the chain. Refused writes are reached by writing the running descriptor with a stop code, then confirming through `rd_cc` and the transfer count that nothing changed.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    localparam int CNT_W = 8;
    localparam int EXP_W = 4;

    localparam logic [2:0] CC_STOP     = 3'b000;
    localparam logic [2:0] CC_PINGPONG = 3'b011;

    typedef struct packed {
        logic [2:0]       cc;
        logic [CNT_W-1:0] cnt_m1;
        logic [EXP_W-1:0] exp;
    } desc_t;

    typedef enum logic [2:0] {
        S_OFF,
        S_LOAD,
        S_ARB,
        S_XFER,
        S_STOP
    } seq_state_e;

    // Mask of burst length minus one; exponents beyond the counter width saturate.
    function automatic logic [CNT_W-1:0] burst_mask(input logic [EXP_W-1:0] e);
        logic [CNT_W-1:0] m;
        for (int i = 0; i < CNT_W; i++) begin
            m[i] = (i < int'(e));
        end
        return m;
    endfunction

    function automatic logic desc_runnable(input desc_t d);
        return d.cc == CC_PINGPONG;
    endfunction

endpackage

// File: rtl/pp_desc_store.sv
module pp_desc_store
    import pp_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       host_we,
    input  logic       host_sel,
    input  desc_t      host_wdata,
    input  logic       act_sel,
    input  logic       protect,
    input  logic       wb_en,
    input  logic       wb_sel,
    input  logic       err_clr,
    output desc_t      act_desc,
    output logic [2:0] rd_cc,
    output logic       wr_err
);

    localparam int NDESC = 2;

    desc_t slot [NDESC];

    logic blocked;
    assign blocked = host_we && protect && (host_sel == act_sel);

    for (genvar g = 0; g < NDESC; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (wb_en && wb_sel == 1'(g)) begin
                slot[g].cc <= CC_STOP;
            end else if (host_we && host_sel == 1'(g) && !(protect && act_sel == 1'(g))) begin
                slot[g] <= host_wdata;
            end
        end

        // R7: completion write-back leaves the finished descriptor stopped
        a_r7_wb_clears: assert property (@(posedge clk) disable iff (rst)
            (wb_en && wb_sel == 1'(g)) |=> (slot[g].cc == CC_STOP));

        // R9: a write aimed at the running descriptor leaves it unchanged
        a_r9_active_kept: assert property (@(posedge clk) disable iff (rst)
            (host_we && protect && host_sel == 1'(g) && act_sel == 1'(g) && !wb_en)
            |=> $stable(slot[g]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_err <= 1'b0;
        end else if (err_clr) begin
            wr_err <= 1'b0;
        end else if (blocked) begin
            wr_err <= 1'b1;
        end
    end

    assign act_desc = slot[act_sel];
    assign rd_cc    = slot[host_sel].cc;

    a_r9_err_set: assert property (@(posedge clk) disable iff (rst)
        (host_we && protect && host_sel == act_sel && !err_clr) |=> wr_err);

endmodule

// File: rtl/pp_xfer_ctr.sv
module pp_xfer_ctr
    import pp_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             burst_clr,
    input  logic             step,
    input  logic [EXP_W-1:0] exp,
    output logic             last_xfer,
    output logic             burst_end
);

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] in_burst;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_cnt;
        end else if (step) begin
            remain <= remain - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_burst <= '0;
        end else if (burst_clr) begin
            in_burst <= '0;
        end else if (step) begin
            in_burst <= in_burst + 1'b1;
        end
    end

    assign last_xfer = (remain == '0);
    assign burst_end = (in_burst == burst_mask(exp));

    // R3: the remaining count moves only on a load or an accepted transfer
    a_r3_remain_holds: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(remain));

endmodule

// File: rtl/pp_seq_fsm.sv
module pp_seq_fsm
    import pp_dma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chan_en,
    input  logic chan_req,
    input  logic grant,
    input  logic mem_ack,
    input  logic act_valid,
    input  logic last_xfer,
    input  logic burst_end,
    output logic mem_req,
    output logic done,
    output logic sel,
    output logic ctr_load,
    output logic burst_clr,
    output logic step,
    output logic wb_en,
    output logic protect,
    output logic err_clr
);

    seq_state_e state, nxt;
    logic       fin;

    assign step      = (state == S_XFER) && mem_ack;
    assign fin       = step && last_xfer && chan_en;
    assign ctr_load  = (state == S_LOAD);
    assign burst_clr = (state == S_ARB);
    assign wb_en     = fin;
    assign protect   = (state == S_LOAD) || (state == S_ARB) || (state == S_XFER);
    assign err_clr   = (state == S_OFF) && chan_en;
    assign mem_req   = (state == S_XFER);

    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:  if (chan_en) nxt = S_LOAD;
            S_LOAD: nxt = act_valid ? S_ARB : S_STOP;
            S_ARB:  if (chan_req && grant) nxt = S_XFER;
            S_XFER: if (step) begin
                        if (last_xfer)      nxt = S_LOAD;
                        else if (burst_end) nxt = S_ARB;
                    end
            S_STOP: nxt = S_STOP;
            default: nxt = S_OFF;
        endcase
        if (!chan_en) nxt = S_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_OFF;
            sel   <= 1'b0;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= fin;
            if (state == S_OFF) begin
                sel <= 1'b0;
            end else if (fin) begin
                sel <= ~sel;
            end
        end
    end

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_flip_with_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (sel != $past(sel)));

    a_r11_start_needs_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(chan_req && grant));

    a_r10_disable_drops: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> !mem_req);

endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq
    import pp_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_en,
    input  logic             chan_req,
    input  logic             grant,
    output logic             mem_req,
    input  logic             mem_ack,
    output logic             done,
    output logic             active_alt,
    input  logic             host_we,
    input  logic             host_sel,
    input  logic [2:0]       host_cc,
    input  logic [CNT_W-1:0] host_cnt,
    input  logic [EXP_W-1:0] host_exp,
    output logic [2:0]       rd_cc,
    output logic             wr_err
);

    desc_t wdata;
    desc_t act_desc;
    logic  sel, ctr_load, burst_clr, step, wb_en, protect, err_clr;
    logic  last_xfer, burst_end;

    assign wdata = '{cc: host_cc, cnt_m1: host_cnt, exp: host_exp};

    pp_desc_store u_store (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (wdata),
        .act_sel    (sel),
        .protect    (protect),
        .wb_en      (wb_en),
        .wb_sel     (sel),
        .err_clr    (err_clr),
        .act_desc   (act_desc),
        .rd_cc      (rd_cc),
        .wr_err     (wr_err)
    );

    pp_xfer_ctr u_ctr (
        .clk        (clk),
        .rst        (rst),
        .load       (ctr_load),
        .load_cnt   (act_desc.cnt_m1),
        .burst_clr  (burst_clr),
        .step       (step),
        .exp        (act_desc.exp),
        .last_xfer  (last_xfer),
        .burst_end  (burst_end)
    );

    pp_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .chan_en    (chan_en),
        .chan_req   (chan_req),
        .grant      (grant),
        .mem_ack    (mem_ack),
        .act_valid  (desc_runnable(act_desc)),
        .last_xfer  (last_xfer),
        .burst_end  (burst_end),
        .mem_req    (mem_req),
        .done       (done),
        .sel        (sel),
        .ctr_load   (ctr_load),
        .burst_clr  (burst_clr),
        .step       (step),
        .wb_en      (wb_en),
        .protect    (protect),
        .err_clr    (err_clr)
    );

    assign active_alt = sel;

endmodule

// File: tb/test_pp_dma_seq.sv
module test_pp_dma_seq;
    import pp_dma_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             chan_en = 1'b0;
    logic             chan_req = 1'b0;
    logic             grant = 1'b1;
    logic             mem_req;
    logic             mem_ack;
    logic             done;
    logic             active_alt;
    logic             host_we = 1'b0;
    logic             host_sel = 1'b0;
    logic [2:0]       host_cc = '0;
    logic [CNT_W-1:0] host_cnt = '0;
    logic [EXP_W-1:0] host_exp = '0;
    logic [2:0]       rd_cc;
    logic             wr_err;

    int checks = 0;
    int errors = 0;

    assign mem_ack = mem_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    pp_dma_seq i_pp_dma_seq (
        .clk(clk), .rst(rst), .chan_en(chan_en), .chan_req(chan_req), .grant(grant),
        .mem_req(mem_req), .mem_ack(mem_ack), .done(done), .active_alt(active_alt),
        .host_we(host_we), .host_sel(host_sel), .host_cc(host_cc), .host_cnt(host_cnt),
        .host_exp(host_exp), .rd_cc(rd_cc), .wr_err(wr_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic s, input logic [2:0] cc, input int cnt_m1, input int e);
        @(negedge clk);
        host_we  = 1'b1;
        host_sel = s;
        host_cc  = cc;
        host_cnt = CNT_W'(cnt_m1);
        host_exp = EXP_W'(e);
        @(negedge clk);
        host_we  = 1'b0;
    endtask

    task automatic read_cc(input logic s, output int v);
        @(negedge clk);
        host_sel = s;
        #1;
        v = int'(rd_cc);
    endtask

    task automatic enable_ch();
        @(negedge clk);
        chan_en = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic disable_ch();
        @(negedge clk);
        chan_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // One request pulse, then count transfers and done pulses over a window.
    task automatic burst(output int xf, output int dn, output int last_i, output int done_i);
        xf = 0; dn = 0; last_i = -1; done_i = -1;
        @(negedge clk);
        chan_req = 1'b1;
        @(negedge clk);
        chan_req = 1'b0;
        for (int i = 0; i < 24; i++) begin
            if (mem_req) begin xf++; last_i = i; end
            if (done)    begin dn++; done_i = i; end
            @(negedge clk);
        end
    endtask

    function automatic int nbursts(input int n, input int e);
        return (n + (1 << e) - 1) >> e;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset mem_req", int'(mem_req), 0);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset active_alt", int'(active_alt), 0);
        chk("R1 reset wr_err", int'(wr_err), 0);
    endtask

    task automatic t_single();
        int xf, dn, li, di, v;
        hwrite(1'b0, CC_PINGPONG, 5, 2);
        hwrite(1'b1, CC_STOP, 3, 1);
        enable_ch();
        chk("R1 enable selects primary", int'(active_alt), 0);
        burst(xf, dn, li, di);
        chk("R4 first burst length", xf, 4);
        chk("R4 no done mid task", dn, 0);
        repeat (6) @(negedge clk);
        chk("R4 idle without new request", int'(mem_req), 0);
        burst(xf, dn, li, di);
        chk("R5 remainder burst", xf, 2);
        chk("R6 one done pulse", dn, 1);
        chk("R6 done one cycle after last transfer", di, li + 1);
        chk("R6 switched to alternate", int'(active_alt), 1);
        read_cc(1'b0, v);
        chk("R7 primary written back", v, 0);
        burst(xf, dn, li, di);
        chk("R2 invalid alternate stops chain", xf, 0);
        disable_ch();
    endtask

    task automatic t_grant();
        int xf, dn, li, di;
        hwrite(1'b0, CC_PINGPONG, 0, 0);
        hwrite(1'b1, CC_STOP, 0, 0);
        enable_ch();
        grant = 1'b0;
        burst(xf, dn, li, di);
        chk("R11 no burst without grant", xf, 0);
        grant = 1'b1;
        burst(xf, dn, li, di);
        chk("R3 count field zero is one transfer", xf, 1);
        chk("R3 single transfer completes task", dn, 1);
        disable_ch();
    endtask

    task automatic t_err();
        int xf, dn, li, di, v, tot;
        hwrite(1'b0, CC_PINGPONG, 3, 1);
        hwrite(1'b1, CC_STOP, 0, 0);
        enable_ch();
        hwrite(1'b0, CC_STOP, 0, 0);
        chk("R9 write to running descriptor flags", int'(wr_err), 1);
        read_cc(1'b0, v);
        chk("R9 running descriptor code kept", v, 3);
        tot = 0;
        burst(xf, dn, li, di);
        tot += xf;
        chk("R9 burst uses original exponent", xf, 2);
        burst(xf, dn, li, di);
        tot += xf;
        chk("R9 task uses original count", tot, 4);
        chk("R9 task completes", dn, 1);
        chk("R9 error is sticky", int'(wr_err), 1);
        disable_ch();
        enable_ch();
        chk("R1 enable clears error", int'(wr_err), 0);
        disable_ch();
    endtask

    task automatic t_disable();
        int xf, dn, li, di;
        hwrite(1'b0, CC_PINGPONG, 9, 4);
        hwrite(1'b1, CC_STOP, 0, 0);
        enable_ch();
        @(negedge clk);
        chan_req = 1'b1;
        @(negedge clk);
        chan_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 transfers running before disable", int'(mem_req), 1);
        chan_en = 1'b0;
        @(negedge clk);
        chk("R10 disable drops request", int'(mem_req), 0);
        repeat (3) @(negedge clk);
        chk("R10 stays quiet while disabled", int'(mem_req), 0);
        enable_ch();
        chk("R1 re-enable selects primary", int'(active_alt), 0);
        burst(xf, dn, li, di);
        chk("R10 restart runs full count", xf, 10);
        chk("R10 restart completes", dn, 1);
        disable_ch();
    endtask

    task automatic t_chain();
        int tn [5] = '{7, 6, 2, 12, 5};
        int te [5] = '{2, 2, 1, 4, 2};
        int xf, dn, li, di, v;
        hwrite(1'b0, CC_PINGPONG, tn[0] - 1, te[0]);
        hwrite(1'b1, CC_PINGPONG, tn[1] - 1, te[1]);
        enable_ch();
        for (int k = 0; k < 5; k++) begin
            int tot = 0, nb = 0, dt = 0, guard = 0;
            while (dt == 0 && guard < 12) begin
                burst(xf, dn, li, di);
                tot += xf;
                if (xf > 0) nb++;
                dt += dn;
                guard++;
            end
            chk($sformatf("R8 task %0d transfer total", k), tot, tn[k]);
            chk($sformatf("R5 task %0d burst count", k), nb, nbursts(tn[k], te[k]));
            chk($sformatf("R6 task %0d done pulses", k), dt, 1);
            chk($sformatf("R6 task %0d active side", k), int'(active_alt), (k + 1) % 2);
            if (k + 2 < 5) hwrite(1'(k % 2), CC_PINGPONG, tn[k+2] - 1, te[k+2]);
        end
        burst(xf, dn, li, di);
        chk("R2 chain ends on written-back alternate", xf, 0);
        chk("R8 refills never flagged", int'(wr_err), 0);
        read_cc(1'b0, v);
        chk("R7 primary stopped after chain", v, 0);
        read_cc(1'b1, v);
        chk("R7 alternate stopped after chain", v, 0);
        disable_ch();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_grant();
        t_err();
        t_disable();
        t_chain();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule